// File: doc/BRIEF.md
# Receive Descriptor DMA Control Engine

This block is the control half of a receive DMA channel. It follows a chain of buffer descriptors held in a word-addressed memory and keeps a pointer to the current descriptor. For each descriptor it checks an ownership flag, hands each arriving frame to a payload mover, and then returns the descriptor to software with the received length. The payload copy itself is modelled as a fixed number of transfer cycles. The MAC and the bus arbitration are outside the block.

Software controls the engine with a level `run_en` bit, a list base address, a poll strobe and two small registers: an interrupt-enable mask and write-one-to-clear status flags. The engine has three visible process states: Stopped, Running and Suspended. Internally, Running is split into the states FETCH, WAIT, XFER and WBACK.

The internal states are S_STOPPED, S_FETCH, S_WAIT, S_XFER, S_WBACK and S_SUSP. Their transitions are:
- STOPPED→FETCH when `run_en` is 1.
- FETCH→SUSP when the first word shows host ownership.
- FETCH→WAIT after the third word.
- WAIT→XFER when a frame is accepted.
- WAIT→STOPPED when `run_en` is 0.
- XFER→WBACK after XFER_CYC cycles.
- WBACK→FETCH when `run_en` is 1, or WBACK→STOPPED when it is 0, once the write is acknowledged.
- SUSP→FETCH on `poll_dmd` while `run_en` is 1.
- SUSP→STOPPED when `run_en` is 0.

Top module: `rxdesc_engine`

## Requirements
- R1: After reset the engine is Stopped (`proc_state`=0). `status`, `irq_en`, `irq` and `missed_cnt` are all 0, and `frm_ready` is 1.
- R2: Setting `run_en` while Stopped starts a descriptor fetch. The fetch reads three words at ptr, ptr+1 and ptr+2. Word 0 holds the ownership flag at bit W-1 (1 = engine owns it) and the buffer length in bits W-2:0. Word 1 is the buffer address and word 2 is the next-descriptor pointer. On the first start after reset, ptr is loaded from `list_base`.
- R3: If word 0 has ownership 0, the engine reads no further words. It enters Suspended (`proc_state`=2) and sets status bit 1 (no buffer).
- R4: While Suspended with `run_en`=1, a `poll_dmd` pulse fetches the same descriptor again.
- R5: A frame accepted in WAIT holds `xfer_active` for exactly XFER_CYC cycles, with `xfer_addr` equal to the buffer address. The engine then writes word 0 at ptr with ownership 0 and length min(frame length, buffer length). It sets status bit 0 (frame done), and ptr becomes the next-descriptor pointer.
- R6: Clearing `run_en` during a transfer lets that frame finish and be written back before the engine stops. `cur_ptr` then holds the next descriptor.
- R7: Clearing `run_en` in WAIT or Suspended stops the engine at the next edge without moving ptr. Every entry to Stopped from another state sets status bit 2.
- R8: A restart after a stop resumes at the saved ptr and ignores `list_base`.
- R9: A stop request during a fetch takes effect only after the fetch completes. While Suspended with `run_en`=1, no memory request is made until `poll_dmd` arrives.
- R10: A frame presented while Stopped or Suspended is dropped with no memory write. It increments `missed_cnt`, which saturates at all ones, and sets status bit 3.
- R11: A `sts_w1c_we` write clears the status bits that are 1 in `sts_w1c_data`. `ien_we` loads `irq_en`. `irq` is the OR of `status & irq_en`.
- R12: `frm_ready` is 0 while a fetch, transfer or writeback is in progress. `mem_req` is never high together with `frm_ready`. A memory request holds its address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Receive run control bit |
| list_base | input | W | Descriptor list base address |
| poll_dmd | input | 1 | Poll strobe to resume from Suspended |
| ien_we | input | 1 | Interrupt-enable write strobe |
| ien_wdata | input | 4 | Interrupt-enable write value |
| sts_w1c_we | input | 1 | Status clear strobe |
| sts_w1c_data | input | 4 | Status bits to clear |
| frm_valid | input | 1 | Frame offered by MAC |
| frm_len | input | W-1 | Length of offered frame |
| frm_ready | output | 1 | Engine takes (or drops) the offered frame |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) / read (0) |
| mem_addr | output | W | Memory word address |
| mem_wdata | output | W | Memory write data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rdata | input | W | Read data, valid with `mem_ack` |
| xfer_active | output | 1 | Payload transfer in progress |
| xfer_addr | output | W | Buffer address for payload mover |
| proc_state | output | 2 | 0 Stopped, 1 Running, 2 Suspended |
| cur_ptr | output | W | Current descriptor pointer |
| status | output | 4 | Status flags (0 done, 1 no buffer, 2 stopped, 3 missed) |
| irq_en | output | 4 | Interrupt enables |
| irq | output | 1 | Interrupt request |
| missed_cnt | output | MW | Saturating missed-frame count |

## Verification
The checker module checks the memory and frame handshakes on every cycle: a request stays stable until it is acknowledged, and `frm_ready` is never high together with `mem_req`. It also checks on every cycle that a rising no-buffer or stopped flag coincides with the matching process state. It checks that `cur_ptr` moves only on a writeback completion or a start, and that `missed_cnt` changes only when a frame is offered outside Running. Only the bench scenarios can show the ordering behaviour and the written values:
- the fetch addresses and the clamped written length;
- stop deferred until after a transfer or a fetch;
- resumption at the saved pointer when `list_base` has changed;
- refetch on poll;
- counter saturation and interrupt masking.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    typedef enum logic [2:0] {
        S_STOPPED = 3'd0,
        S_FETCH   = 3'd1,
        S_WAIT    = 3'd2,
        S_XFER    = 3'd3,
        S_WBACK   = 3'd4,
        S_SUSP    = 3'd5
    } eng_state_t;

    typedef enum logic [1:0] {
        P_STOPPED   = 2'd0,
        P_RUNNING   = 2'd1,
        P_SUSPENDED = 2'd2
    } proc_t;

    localparam int NSTAT    = 4;
    localparam int ST_DONE  = 0;
    localparam int ST_NOBUF = 1;
    localparam int ST_STOP  = 2;
    localparam int ST_MISS  = 3;
    localparam int DESC_WORDS = 3;
endpackage

// File: rtl/rxd_fsm.sv
module rxd_fsm
    import rxd_pkg::*;
#(
    parameter int W        = 16,
    parameter int XFER_CYC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [W-1:0] list_base,
    input  logic         poll_dmd,
    input  logic         frm_valid,
    input  logic [W-2:0] frm_len,
    input  logic         mem_ack,
    input  logic [W-1:0] mem_rdata,
    output logic         frm_ready,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         xfer_active,
    output logic [W-1:0] xfer_addr,
    output logic [1:0]   proc_state,
    output logic [W-1:0] cur_ptr,
    output logic         ev_done,
    output logic         ev_nobuf,
    output logic         ev_stop,
    output logic         ev_miss
);
    localparam int LW  = W - 1;
    localparam int XCW = (XFER_CYC < 2) ? 1 : $clog2(XFER_CYC);
    localparam logic [XCW-1:0] XC_LAST = XCW'(XFER_CYC - 1);
    localparam logic [1:0] WIDX_LAST = 2'(DESC_WORDS - 1);

    eng_state_t st_q, st_n;

    logic [W-1:0]   ptr_q;
    logic           ptr_ok_q;
    logic [1:0]     widx_q;
    logic [LW-1:0]  buf_len_q;
    logic [W-1:0]   buf_addr_q;
    logic [W-1:0]   nxt_q;
    logic [LW-1:0]  flen_q;
    logic [XCW-1:0] xcnt_q;

    logic own_bit;
    logic accept;
    logic [LW-1:0] wlen;

    assign own_bit = mem_rdata[W-1];
    assign accept  = (st_q == S_WAIT) && run_en && frm_valid;
    assign wlen    = (flen_q < buf_len_q) ? flen_q : buf_len_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_STOPPED;
        else        st_q <= st_n;
    end

    // next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            S_STOPPED: if (run_en) st_n = S_FETCH;
            S_FETCH: begin
                if (mem_ack) begin
                    if (widx_q == 2'd0 && !own_bit) st_n = S_SUSP;
                    else if (widx_q == WIDX_LAST)   st_n = S_WAIT;
                end
            end
            S_WAIT: begin
                if (!run_en)         st_n = S_STOPPED;
                else if (frm_valid)  st_n = S_XFER;
            end
            S_XFER:  if (xcnt_q == XC_LAST) st_n = S_WBACK;
            S_WBACK: if (mem_ack) st_n = run_en ? S_FETCH : S_STOPPED;
            S_SUSP: begin
                if (!run_en)       st_n = S_STOPPED;
                else if (poll_dmd) st_n = S_FETCH;
            end
            default: st_n = S_STOPPED;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            ptr_ok_q   <= 1'b0;
            widx_q     <= '0;
            buf_len_q  <= '0;
            buf_addr_q <= '0;
            nxt_q      <= '0;
            flen_q     <= '0;
            xcnt_q     <= '0;
        end else begin
            if (st_q == S_STOPPED && st_n == S_FETCH && !ptr_ok_q) begin
                ptr_q    <= list_base;
                ptr_ok_q <= 1'b1;
            end
            if (st_q == S_FETCH && mem_ack) begin
                if (widx_q == 2'd0)      buf_len_q  <= mem_rdata[LW-1:0];
                else if (widx_q == 2'd1) buf_addr_q <= mem_rdata;
                else                     nxt_q      <= mem_rdata;
                widx_q <= (st_n == S_FETCH) ? widx_q + 2'd1 : 2'd0;
            end
            if (accept) begin
                flen_q <= frm_len;
                xcnt_q <= '0;
            end else if (st_q == S_XFER) begin
                xcnt_q <= xcnt_q + XCW'(1);
            end
            if (st_q == S_WBACK && mem_ack) ptr_q <= nxt_q;
        end
    end

    // outputs
    always_comb begin
        frm_ready   = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = ptr_q + W'(widx_q);
        mem_wdata   = {1'b0, wlen};
        xfer_active = 1'b0;
        proc_state  = P_RUNNING;
        unique case (st_q)
            S_STOPPED: begin
                frm_ready  = 1'b1;
                proc_state = P_STOPPED;
            end
            S_FETCH: mem_req = 1'b1;
            S_WAIT:  frm_ready = run_en;
            S_XFER:  xfer_active = 1'b1;
            S_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = ptr_q;
            end
            S_SUSP: begin
                frm_ready  = 1'b1;
                proc_state = P_SUSPENDED;
            end
            default: proc_state = P_STOPPED;
        endcase
    end

    assign xfer_addr = buf_addr_q;
    assign cur_ptr   = ptr_q;
    assign ev_done   = (st_q == S_WBACK) && mem_ack;
    assign ev_nobuf  = (st_q == S_FETCH) && mem_ack && (widx_q == 2'd0) && !own_bit;
    assign ev_stop   = (st_q != S_STOPPED) && (st_n == S_STOPPED);
    assign ev_miss   = frm_valid && (st_q == S_STOPPED || st_q == S_SUSP);
endmodule

// File: rtl/rxd_status.sv
module rxd_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         w1c_we,
    input  logic [N-1:0] w1c_data,
    input  logic         ien_we,
    input  logic [N-1:0] ien_wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] irq_en,
    output logic         irq
);
    logic [N-1:0] clr_mask;
    assign clr_mask = w1c_we ? w1c_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            irq_en <= '0;
        end else begin
            status <= (status & ~clr_mask) | ev;
            if (ien_we) irq_en <= ien_wdata;
        end
    end

    assign irq = |(status & irq_en);
endmodule

// File: rtl/rxd_miss_ctr.sv
module rxd_miss_ctr #(
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [MW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (inc && cnt != '1)  cnt <= cnt + MW'(1);
    end
endmodule

// File: rtl/rxdesc_engine.sv
module rxdesc_engine
    import rxd_pkg::*;
#(
    parameter int W        = 16,
    parameter int XFER_CYC = 4,
    parameter int MW       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [W-1:0]     list_base,
    input  logic             poll_dmd,
    input  logic             ien_we,
    input  logic [NSTAT-1:0] ien_wdata,
    input  logic             sts_w1c_we,
    input  logic [NSTAT-1:0] sts_w1c_data,
    input  logic             frm_valid,
    input  logic [W-2:0]     frm_len,
    output logic             frm_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic             mem_ack,
    input  logic [W-1:0]     mem_rdata,
    output logic             xfer_active,
    output logic [W-1:0]     xfer_addr,
    output logic [1:0]       proc_state,
    output logic [W-1:0]     cur_ptr,
    output logic [NSTAT-1:0] status,
    output logic [NSTAT-1:0] irq_en,
    output logic             irq,
    output logic [MW-1:0]    missed_cnt
);
    logic ev_done, ev_nobuf, ev_stop, ev_miss;
    logic [NSTAT-1:0] ev_vec;

    rxd_fsm #(.W(W), .XFER_CYC(XFER_CYC)) fsm_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .list_base(list_base),
        .poll_dmd(poll_dmd), .frm_valid(frm_valid), .frm_len(frm_len),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .frm_ready(frm_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .xfer_active(xfer_active), .xfer_addr(xfer_addr),
        .proc_state(proc_state), .cur_ptr(cur_ptr), .ev_done(ev_done),
        .ev_nobuf(ev_nobuf), .ev_stop(ev_stop), .ev_miss(ev_miss)
    );

    always_comb begin
        ev_vec           = '0;
        ev_vec[ST_DONE]  = ev_done;
        ev_vec[ST_NOBUF] = ev_nobuf;
        ev_vec[ST_STOP]  = ev_stop;
        ev_vec[ST_MISS]  = ev_miss;
    end

    rxd_status #(.N(NSTAT)) sts_i (
        .clk(clk), .rst_n(rst_n), .ev(ev_vec), .w1c_we(sts_w1c_we),
        .w1c_data(sts_w1c_data), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .status(status), .irq_en(irq_en), .irq(irq)
    );

    rxd_miss_ctr #(.MW(MW)) miss_i (
        .clk(clk), .rst_n(rst_n), .inc(ev_miss), .cnt(missed_cnt)
    );
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker
    import rxd_pkg::*;
#(
    parameter int W  = 16,
    parameter int MW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_valid,
    input logic             frm_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [W-1:0]     mem_addr,
    input logic             mem_ack,
    input logic [1:0]       proc_state,
    input logic [W-1:0]     cur_ptr,
    input logic [NSTAT-1:0] status,
    input logic [NSTAT-1:0] irq_en,
    input logic             irq,
    input logic [MW-1:0]    missed_cnt
);
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (status == '0 && irq_en == '0 && !irq &&
                                           missed_cnt == '0 && proc_state == P_STOPPED);
        end
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_ready_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_ready && mem_req));

    assert_nobuf_susp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_NOBUF]) |-> (proc_state == P_SUSPENDED));

    assert_stop_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_STOP]) |-> (proc_state == P_STOPPED));

    assert_ptr_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ptr != $past(cur_ptr)) |-> ($past(mem_we && mem_ack) || $past(proc_state == P_STOPPED)));

    assert_miss_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_cnt != $past(missed_cnt)) |-> $past(frm_valid && proc_state != P_RUNNING));
endmodule

bind rxdesc_engine rxd_checker #(.W(W), .MW(MW)) chk_i (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .proc_state(proc_state), .cur_ptr(cur_ptr), .status(status),
    .irq_en(irq_en), .irq(irq), .missed_cnt(missed_cnt)
);

// File: tb/rxdesc_engine_tb_top.sv
module rxdesc_engine_tb_top;
    localparam int W  = 16;
    localparam int MW = 3;
    localparam int XC = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, run_en, poll_dmd, ien_we, sts_w1c_we, frm_valid;
    logic [W-1:0] list_base;
    logic [3:0] ien_wdata, sts_w1c_data;
    logic [W-2:0] frm_len;
    logic frm_ready, mem_req, mem_we, mem_ack, xfer_active, irq;
    logic [W-1:0] mem_addr, mem_wdata, mem_rdata, xfer_addr, cur_ptr;
    logic [1:0] proc_state;
    logic [3:0] status, irq_en;
    logic [MW-1:0] missed_cnt;

    rxdesc_engine #(.W(W), .XFER_CYC(XC), .MW(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .list_base(list_base),
        .poll_dmd(poll_dmd), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .sts_w1c_we(sts_w1c_we), .sts_w1c_data(sts_w1c_data),
        .frm_valid(frm_valid), .frm_len(frm_len), .frm_ready(frm_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .xfer_active(xfer_active), .xfer_addr(xfer_addr),
        .proc_state(proc_state), .cur_ptr(cur_ptr), .status(status),
        .irq_en(irq_en), .irq(irq), .missed_cnt(missed_cnt)
    );

    // memory model: one-cycle latency, ack pulse
    logic [W-1:0] mem [0:255];
    logic [W-1:0] rd_log [0:63];
    int rd_cnt, wr_cnt;
    logic pk_en;
    logic [7:0] pk_a;
    logic [W-1:0] pk_d;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            rd_cnt    <= 0;
            wr_cnt    <= 0;
        end else begin
            if (pk_en) mem[pk_a] <= pk_d;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[7:0]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[7:0]];
                    rd_log[rd_cnt[5:0]] <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    int total = 0, bad = 0;
    bit fin = 1'b0;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", r, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [W-1:0] d);
        pk_en = 1'b1; pk_a = a; pk_d = d;
        @(negedge clk);
        pk_en = 1'b0;
    endtask

    task automatic wait_ps(input logic [1:0] ps, input logic rdy, input string r);
        int n = 0;
        while (!(proc_state == ps && frm_ready == rdy) && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(r, n < 300, 1);
    endtask

    task automatic clear_status();
        sts_w1c_we = 1'b1; sts_w1c_data = 4'hF;
        @(negedge clk);
        sts_w1c_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 state", proc_state, 0);
        chk("R1 status", status, 0);
        chk("R1 irq_en", irq_en, 0);
        chk("R1 irq", irq, 0);
        chk("R1 missed", missed_cnt, 0);
        chk("R1 ready", frm_ready, 1);
    endtask

    task automatic t_miss_stopped();
        int w0 = wr_cnt;
        frm_valid = 1'b1; frm_len = 15'd30;
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R10 missed count stopped", missed_cnt, 1);
        chk("R10 miss status", status[3], 1);
        @(negedge clk);
        chk("R10 no write", wr_cnt - w0, 0);
    endtask

    task automatic t_irq();
        chk("R11 masked irq", irq, 0);
        ien_we = 1'b1; ien_wdata = 4'b0001;
        @(negedge clk);
        ien_we = 1'b0;
        chk("R11 irq_en load", irq_en, 4'b0001);
        chk("R11 other bit masked", irq, 0);
        ien_we = 1'b1; ien_wdata = 4'b1000;
        @(negedge clk);
        ien_we = 1'b0;
        chk("R11 irq raised", irq, 1);
        sts_w1c_we = 1'b1; sts_w1c_data = 4'b1000;
        @(negedge clk);
        sts_w1c_we = 1'b0;
        chk("R11 w1c clears", status, 0);
        chk("R11 irq drops", irq, 0);
    endtask

    task automatic t_start();
        int r0 = rd_cnt;
        run_en = 1'b1;
        wait_ps(2'd1, 1'b1, "R2 reach wait");
        chk("R2 ptr from base", cur_ptr, 16'h0010);
        chk("R2 read count", rd_cnt - r0, 3);
        chk("R2 read addr0", rd_log[r0[5:0]], 16'h0010);
        chk("R2 read addr2", rd_log[6'(r0 + 2)], 16'h0012);
    endtask

    task automatic send_frame(input logic [W-2:0] len, input int stop_after);
        frm_valid = 1'b1; frm_len = len;
        @(negedge clk);
        frm_valid = 1'b0;
        if (stop_after != 0) run_en = 1'b0;
    endtask

    task automatic t_frames();
        int n = 0;
        send_frame(15'd60, 0);
        while (xfer_active) begin
            chk("R12 ready low in xfer", frm_ready, 0);
            chk("R5 xfer addr", xfer_addr, 16'hA000);
            n++;
            @(negedge clk);
        end
        chk("R5 xfer cycles", n, XC);
        wait_ps(2'd1, 1'b1, "R5 back to wait");
        chk("R5 writeback len", mem[8'h10], 16'h003C);
        chk("R5 ptr advanced", cur_ptr, 16'h0020);
        chk("R5 done flag", status[0], 1);
        clear_status();
        send_frame(15'd50, 0);
        wait_ps(2'd2, 1'b1, "R3 reach suspended");
        chk("R5 clamped len", mem[8'h20], 16'h0014);
        chk("R3 nobuf flag", status[1], 1);
        chk("R3 ptr at owned-by-host", cur_ptr, 16'h0030);
    endtask

    task automatic t_poll();
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        repeat (10) @(negedge clk);
        chk("R9 no fetch while suspended", rd_cnt - r0, 0);
        frm_valid = 1'b1; frm_len = 15'd5;
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R10 missed in suspended", missed_cnt, 2);
        chk("R10 no write suspended", wr_cnt - w0, 0);
        poke(8'h30, 16'h8028);
        poke(8'h31, 16'hC000);
        poke(8'h32, 16'h0010);
        r0 = rd_cnt;
        poll_dmd = 1'b1;
        @(negedge clk);
        poll_dmd = 1'b0;
        wait_ps(2'd1, 1'b1, "R4 resumed");
        chk("R4 refetch same", rd_log[r0[5:0]], 16'h0030);
        chk("R4 ptr", cur_ptr, 16'h0030);
    endtask

    task automatic t_stop_wait();
        clear_status();
        run_en = 1'b0;
        @(negedge clk);
        chk("R7 stopped", proc_state, 0);
        chk("R7 stop flag", status[2], 1);
        chk("R7 ptr kept", cur_ptr, 16'h0030);
    endtask

    task automatic t_restart();
        int r0 = rd_cnt;
        list_base = 16'h0050;
        run_en = 1'b1;
        wait_ps(2'd1, 1'b1, "R8 restarted");
        chk("R8 saved position", rd_log[r0[5:0]], 16'h0030);
        chk("R8 ptr", cur_ptr, 16'h0030);
    endtask

    task automatic t_stop_xfer();
        clear_status();
        send_frame(15'd10, 1);
        wait_ps(2'd0, 1'b1, "R6 stopped");
        chk("R6 frame written", mem[8'h30], 16'h000A);
        chk("R6 ptr next", cur_ptr, 16'h0010);
        chk("R6 done flag", status[0], 1);
        chk("R6 stop flag", status[2], 1);
    endtask

    task automatic t_stop_fetch();
        int r0;
        poke(8'h10, 16'h8064);
        r0 = rd_cnt;
        run_en = 1'b1;
        @(negedge clk);
        run_en = 1'b0;
        chk("R9 fetch running", proc_state, 1);
        wait_ps(2'd0, 1'b1, "R9 stopped after fetch");
        chk("R9 fetch completed", rd_cnt - r0, 3);
        chk("R9 ptr", cur_ptr, 16'h0010);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 8; i++) begin
            frm_valid = 1'b1; frm_len = 15'd1;
            @(negedge clk);
        end
        frm_valid = 1'b0;
        @(negedge clk);
        chk("R10 saturate", missed_cnt, 7);
    endtask

    initial begin
        rst_n = 1'b0; run_en = 1'b0; poll_dmd = 1'b0; ien_we = 1'b0;
        sts_w1c_we = 1'b0; frm_valid = 1'b0; list_base = 16'h0010;
        ien_wdata = '0; sts_w1c_data = '0; frm_len = '0;
        pk_en = 1'b0; pk_a = '0; pk_d = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        poke(8'h10, 16'h8064); poke(8'h11, 16'hA000); poke(8'h12, 16'h0020);
        poke(8'h20, 16'h8014); poke(8'h21, 16'hB000); poke(8'h22, 16'h0030);
        t_miss_stopped();
        t_irq();
        t_start();
        t_frames();
        t_poll();
        t_stop_wait();
        t_restart();
        t_stop_xfer();
        t_stop_fetch();
        t_saturate();
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule